// File: doc/BRIEF.md
# Answer-to-reset parameter extractor

After a card is reset it announces its transmission parameters in a short byte string. This block sits behind a character receiver, takes that string one byte at a time through a valid/data pair, and turns it into registered parameter outputs. These outputs cover the signalling convention, the clock-rate and bit-rate indices, the extra guard code, the first offered protocol and the specific-mode settings. They also cover the block-protocol parameters: largest information field the card accepts, character and block waiting indices, and check type. The block also gives the number of historical bytes, a one-cycle completion pulse and a check-byte mismatch flag.

The string is not of fixed length. A format byte and every chaining byte carry a four-bit presence map that says which of up to four interface bytes follow in the next group. The extractor walks this chain, then counts off the historical bytes. When any chaining byte offered a protocol other than 0, it also takes a closing check byte. All bytes after the initial one are assumed to arrive already in logical form; the block only reports which convention the initial byte chose. A synchronous `card_reset` pulse arms it for a fresh string and restores the defaults.

Top module: `atr_parser`

## Requirements
- R1: The first byte after a restart sets `conv_inverse` to 1 when it is 0x3F and to 0 for any other value.
- R2: The second byte is the format byte: its bits 4, 5, 6 and 7 announce the first-group bytes A, B, C and D (in that order on the wire), and its bits 3:0 give the historical byte count, shown on `hist_cnt`.
- R3: A first-group A byte drives `fi_idx` from its bits 7:4 and `di_idx` from its bits 3:0; a first-group C byte drives `guard_code`; a first-group B byte changes no output.
- R4: Each D byte's bits 7:4 announce the next group's A, B, C, D bytes in the same bit order; the first D byte's bits 3:0 drive `proto_type`.
- R5: A second-group A byte sets `spec_mode` to 1, `spec_lock` to its bit 7 and `spec_proto` to its bits 3:0 (0x81 gives lock 1, protocol 1).
- R6: In the third group, A drives `ifsc`, B drives `bwi` from bits 7:4 and `cwi` from bits 3:0, and bit 0 of C drives `crc_sel` (0 selects XOR check, 1 selects CRC).
- R7: Parameters whose byte is absent keep their defaults: `fi_idx` 1, `di_idx` 1, `guard_code` 0, `proto_type` 0, `ifsc` 32, `cwi` 13, `bwi` 4, `crc_sel` 0, `spec_mode` 0; these values appear in the cycle after reset or `card_reset`.
- R8: A check byte is expected only if some D byte carried a nonzero protocol nibble; `done` is high for exactly one cycle, the cycle after the final byte (check byte, else last historical byte, else last interface byte) is accepted.
- R9: `chk_err` is set together with `done` when the XOR of every byte from the format byte through the check byte is nonzero, and stays 0 when no check byte is expected.
- R10: Bytes offered after completion change no output and raise no `done` until `card_reset`, which starts a new string.
- R11: Cycles with `byte_vld` low neither advance the parse nor change any output, whatever `byte_dat` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_reset | input | 1 | Synchronous pulse: discard the current parse and restore defaults |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_dat | input | 8 | Received byte |
| conv_inverse | output | 1 | Initial byte selected inverse convention |
| fi_idx | output | 4 | Clock-rate conversion index |
| di_idx | output | 4 | Bit-rate adjustment index |
| guard_code | output | 8 | Extra guard time code |
| proto_type | output | 4 | Protocol from the first chaining byte |
| ifsc | output | 8 | Largest information field the card accepts |
| cwi | output | 4 | Character waiting index |
| bwi | output | 4 | Block waiting index |
| crc_sel | output | 1 | 1 selects CRC, 0 selects XOR check |
| spec_mode | output | 1 | Card fixed a specific mode |
| spec_lock | output | 1 | Specific mode may not be changed |
| spec_proto | output | 4 | Protocol of the specific mode |
| hist_cnt | output | 4 | Number of historical bytes |
| done | output | 1 | One-cycle pulse at the end of the string |
| chk_err | output | 1 | Check byte mismatch, valid from `done` |

## Verification
The parse position is the hidden state. If the pending-byte map or the group counter is wrong, the next interface byte is given the wrong role. A parameter output then changes one cycle after that byte, or a default is left in place. A wrong historical count or check-byte decision moves `done` earlier or later than the final byte, and the bench checks this for every string. A corrupted running XOR shows only at `done`, through `chk_err`. Sweeping every format-byte presence map against four chain shapes drives each role decision at least once.

// File: rtl/atr_pkg.sv
`timescale 1ns/1ps
// Shared types for the answer-to-reset extractor.
package atr_pkg;

    // Meaning given to the byte currently on the input.
    typedef enum logic [3:0] {
        ROLE_TS,
        ROLE_FMT,
        ROLE_TA,
        ROLE_TB,
        ROLE_TC,
        ROLE_TD,
        ROLE_HIST,
        ROLE_TCK,
        ROLE_NONE
    } role_t;

    // Parse position.
    typedef enum logic [2:0] {
        ST_TS,
        ST_FMT,
        ST_IFC,
        ST_HIST,
        ST_TCK,
        ST_FIN
    } seq_st_t;

    localparam logic [7:0] TS_INVERSE = 8'h3F;

endpackage

// File: rtl/atr_seq.sv
`timescale 1ns/1ps
// Parse sequencer: decides the role of each incoming byte by following
// the presence maps of the format and chaining bytes, counts historical
// bytes and decides whether a check byte closes the string.
// Assumes byte_vld is a one-cycle qualifier per byte.
module atr_seq
    import atr_pkg::*;
#(
    parameter int GRP_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             vld,
    input  logic [7:0]       dat,
    output role_t            role,
    output logic [GRP_W-1:0] grp,
    output logic             last
);

    localparam logic [GRP_W-1:0] GRP_MAX   = '1;
    localparam logic [GRP_W-1:0] GRP_FIRST = GRP_W'(1);

    seq_st_t          st, st_n;
    logic [3:0]       pend, pend_n;
    logic [3:0]       hist_left, hist_n;
    logic             tck_need, tck_n;
    logic [GRP_W-1:0] grp_n;

    // Role of the current byte from position and lowest pending presence bit.
    always_comb begin
        case (st)
            ST_TS:   role = ROLE_TS;
            ST_FMT:  role = ROLE_FMT;
            ST_IFC: begin
                if (pend[0])      role = ROLE_TA;
                else if (pend[1]) role = ROLE_TB;
                else if (pend[2]) role = ROLE_TC;
                else              role = ROLE_TD;
            end
            ST_HIST: role = ROLE_HIST;
            ST_TCK:  role = ROLE_TCK;
            default: role = ROLE_NONE;
        endcase
    end

    // Next parse position if the current byte is accepted.
    always_comb begin
        pend_n = pend;
        hist_n = hist_left;
        tck_n  = tck_need;
        grp_n  = grp;
        st_n   = st;
        case (role)
            ROLE_TS:  st_n = ST_FMT;
            ROLE_FMT: begin
                pend_n = dat[7:4];
                hist_n = dat[3:0];
                grp_n  = GRP_FIRST;
            end
            ROLE_TA:  pend_n[0] = 1'b0;
            ROLE_TB:  pend_n[1] = 1'b0;
            ROLE_TC:  pend_n[2] = 1'b0;
            ROLE_TD: begin
                pend_n = dat[7:4];
                if (grp != GRP_MAX) grp_n = grp + 1'b1;
                if (dat[3:0] != 4'd0) tck_n = 1'b1;
            end
            ROLE_HIST: hist_n = hist_left - 4'd1;
            ROLE_TCK:  st_n = ST_FIN;
            default: ;
        endcase
        if (role inside {ROLE_FMT, ROLE_TA, ROLE_TB, ROLE_TC, ROLE_TD, ROLE_HIST}) begin
            if (pend_n != 4'd0)      st_n = ST_IFC;
            else if (hist_n != 4'd0) st_n = ST_HIST;
            else if (tck_n)          st_n = ST_TCK;
            else                     st_n = ST_FIN;
        end
    end

    assign last = vld && (st != ST_FIN) && (st_n == ST_FIN);

    // Advance the parse position on every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            st        <= ST_TS;
            pend      <= 4'd0;
            hist_left <= 4'd0;
            tck_need  <= 1'b0;
            grp       <= '0;
        end else if (vld) begin
            st        <= st_n;
            pend      <= pend_n;
            hist_left <= hist_n;
            tck_need  <= tck_n;
            grp       <= grp_n;
        end
    end

endmodule

// File: rtl/atr_fields.sv
`timescale 1ns/1ps
// Parameter capture: loads each output register from the byte whose
// role and group select it; all others keep their defaults.
// Assumes role and grp come from atr_seq for the same byte.
module atr_fields
    import atr_pkg::*;
#(
    parameter int         GRP_W    = 3,
    parameter int         BLK_GRP  = 3,
    parameter logic [3:0] DEF_FI   = 4'd1,
    parameter logic [3:0] DEF_DI   = 4'd1,
    parameter logic [7:0] DEF_IFSC = 8'd32,
    parameter logic [3:0] DEF_CWI  = 4'd13,
    parameter logic [3:0] DEF_BWI  = 4'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             vld,
    input  role_t            role,
    input  logic [GRP_W-1:0] grp,
    input  logic [7:0]       dat,
    output logic             conv_inverse,
    output logic [3:0]       fi_idx,
    output logic [3:0]       di_idx,
    output logic [7:0]       guard_code,
    output logic [3:0]       proto_type,
    output logic [7:0]       ifsc,
    output logic [3:0]       cwi,
    output logic [3:0]       bwi,
    output logic             crc_sel,
    output logic             spec_mode,
    output logic             spec_lock,
    output logic [3:0]       spec_proto,
    output logic [3:0]       hist_cnt
);

    localparam logic [GRP_W-1:0] G1 = GRP_W'(1);
    localparam logic [GRP_W-1:0] G2 = GRP_W'(2);
    localparam logic [GRP_W-1:0] GB = GRP_W'(BLK_GRP);

    // Load defaults on restart, otherwise capture the selected field.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            conv_inverse <= 1'b0;
            fi_idx       <= DEF_FI;
            di_idx       <= DEF_DI;
            guard_code   <= 8'd0;
            proto_type   <= 4'd0;
            ifsc         <= DEF_IFSC;
            cwi          <= DEF_CWI;
            bwi          <= DEF_BWI;
            crc_sel      <= 1'b0;
            spec_mode    <= 1'b0;
            spec_lock    <= 1'b0;
            spec_proto   <= 4'd0;
            hist_cnt     <= 4'd0;
        end else if (vld) begin
            case (role)
                ROLE_TS:  conv_inverse <= (dat == TS_INVERSE);
                ROLE_FMT: hist_cnt <= dat[3:0];
                ROLE_TA: begin
                    if (grp == G1) begin
                        fi_idx <= dat[7:4];
                        di_idx <= dat[3:0];
                    end else if (grp == G2) begin
                        spec_mode  <= 1'b1;
                        spec_lock  <= dat[7];
                        spec_proto <= dat[3:0];
                    end else if (grp == GB) begin
                        ifsc <= dat;
                    end
                end
                ROLE_TB: begin
                    if (grp == GB) begin
                        bwi <= dat[7:4];
                        cwi <= dat[3:0];
                    end
                end
                ROLE_TC: begin
                    if (grp == G1)      guard_code <= dat;
                    else if (grp == GB) crc_sel <= dat[0];
                end
                ROLE_TD: begin
                    if (grp == G1) proto_type <= dat[3:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/atr_lrc.sv
`timescale 1ns/1ps
// Running XOR over every byte after the initial one; at the final
// byte it raises the completion pulse and judges the check byte.
// Assumes last marks the byte that ends the string.
module atr_lrc
    import atr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       vld,
    input  role_t      role,
    input  logic       last,
    input  logic [7:0] dat,
    output logic       done,
    output logic       chk_err
);

    logic [7:0] acc;

    // Accumulate the XOR of all counted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) acc <= 8'd0;
        else if (vld && role != ROLE_TS && role != ROLE_NONE) acc <= acc ^ dat;
    end

    // Completion pulse and check verdict, registered together.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            done    <= 1'b0;
            chk_err <= 1'b0;
        end else begin
            done <= last;
            if (last) chk_err <= (role == ROLE_TCK) && ((acc ^ dat) != 8'd0);
        end
    end

endmodule

// File: rtl/atr_parser.sv
`timescale 1ns/1ps
// Answer-to-reset extractor top: sequencer, parameter capture and check
// unit. Assumes bytes after the initial one arrive in logical form.
module atr_parser
    import atr_pkg::*;
#(
    parameter int         GRP_W    = 3,
    parameter int         BLK_GRP  = 3,
    parameter logic [3:0] DEF_FI   = 4'd1,
    parameter logic [3:0] DEF_DI   = 4'd1,
    parameter logic [7:0] DEF_IFSC = 8'd32,
    parameter logic [3:0] DEF_CWI  = 4'd13,
    parameter logic [3:0] DEF_BWI  = 4'd4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       card_reset,
    input  logic       byte_vld,
    input  logic [7:0] byte_dat,
    output logic       conv_inverse,
    output logic [3:0] fi_idx,
    output logic [3:0] di_idx,
    output logic [7:0] guard_code,
    output logic [3:0] proto_type,
    output logic [7:0] ifsc,
    output logic [3:0] cwi,
    output logic [3:0] bwi,
    output logic       crc_sel,
    output logic       spec_mode,
    output logic       spec_lock,
    output logic [3:0] spec_proto,
    output logic [3:0] hist_cnt,
    output logic       done,
    output logic       chk_err
);

    role_t            role;
    logic [GRP_W-1:0] grp;
    logic             last;

    atr_seq #(.GRP_W(GRP_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (card_reset),
        .vld     (byte_vld),
        .dat     (byte_dat),
        .role    (role),
        .grp     (grp),
        .last    (last)
    );

    atr_fields #(
        .GRP_W    (GRP_W),
        .BLK_GRP  (BLK_GRP),
        .DEF_FI   (DEF_FI),
        .DEF_DI   (DEF_DI),
        .DEF_IFSC (DEF_IFSC),
        .DEF_CWI  (DEF_CWI),
        .DEF_BWI  (DEF_BWI)
    ) u_fields (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (card_reset),
        .vld          (byte_vld),
        .role         (role),
        .grp          (grp),
        .dat          (byte_dat),
        .conv_inverse (conv_inverse),
        .fi_idx       (fi_idx),
        .di_idx       (di_idx),
        .guard_code   (guard_code),
        .proto_type   (proto_type),
        .ifsc         (ifsc),
        .cwi          (cwi),
        .bwi          (bwi),
        .crc_sel      (crc_sel),
        .spec_mode    (spec_mode),
        .spec_lock    (spec_lock),
        .spec_proto   (spec_proto),
        .hist_cnt     (hist_cnt)
    );

    atr_lrc u_lrc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (card_reset),
        .vld     (byte_vld),
        .role    (role),
        .last    (last),
        .dat     (byte_dat),
        .done    (done),
        .chk_err (chk_err)
    );

endmodule

// File: rtl/atr_parser_chk.sv
`timescale 1ns/1ps
// Port-level temporal checks for atr_parser, attached by bind.
module atr_parser_chk #(
    parameter logic [3:0] DEF_FI   = 4'd1,
    parameter logic [3:0] DEF_DI   = 4'd1,
    parameter logic [7:0] DEF_IFSC = 8'd32,
    parameter logic [3:0] DEF_CWI  = 4'd13,
    parameter logic [3:0] DEF_BWI  = 4'd4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       card_reset,
    input logic       byte_vld,
    input logic [7:0] byte_dat,
    input logic       conv_inverse,
    input logic [3:0] fi_idx,
    input logic [3:0] di_idx,
    input logic [7:0] guard_code,
    input logic [3:0] proto_type,
    input logic [7:0] ifsc,
    input logic [3:0] cwi,
    input logic [3:0] bwi,
    input logic       crc_sel,
    input logic       spec_mode,
    input logic       spec_lock,
    input logic [3:0] spec_proto,
    input logic [3:0] hist_cnt,
    input logic       done,
    input logic       chk_err
);

    logic fin_q;

    // Remember that the string has completed until the next restart.
    always_ff @(posedge clk) begin
        if (!rst_n || card_reset) fin_q <= 1'b0;
        else if (done)            fin_q <= 1'b1;
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(byte_vld));

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chk_err) |-> done);

    a_r7_restart_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        card_reset |=> (fi_idx == DEF_FI && di_idx == DEF_DI && ifsc == DEF_IFSC &&
                        cwi == DEF_CWI && bwi == DEF_BWI && !crc_sel && !spec_mode &&
                        guard_code == 8'd0 && proto_type == 4'd0 &&
                        hist_cnt == 4'd0 && !chk_err && !done));

    a_r10_hold_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_q && !card_reset) |=> ($stable(ifsc) && $stable(fi_idx) &&
                                    $stable(hist_cnt) && $stable(chk_err) &&
                                    $stable(guard_code) && !done));

    a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !card_reset) |=> ($stable(ifsc) && $stable(fi_idx) &&
                                        $stable(di_idx) && $stable(guard_code) &&
                                        $stable(hist_cnt) && $stable(spec_mode) &&
                                        $stable(conv_inverse) && !done));

endmodule

bind atr_parser atr_parser_chk #(
    .DEF_FI   (DEF_FI),
    .DEF_DI   (DEF_DI),
    .DEF_IFSC (DEF_IFSC),
    .DEF_CWI  (DEF_CWI),
    .DEF_BWI  (DEF_BWI)
) u_chk (.*);

// File: tb/atr_parser_bench.sv
`timescale 1ns/1ps
module atr_parser_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_reset = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_dat = 8'h00;
    logic       conv_inverse, crc_sel, spec_mode, spec_lock, done, chk_err;
    logic [3:0] fi_idx, di_idx, proto_type, cwi, bwi, spec_proto, hist_cnt;
    logic [7:0] guard_code, ifsc;

    always #10 clk = ~clk;

    atr_parser u_atr_parser (.*);

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] frame [0:63];
    int flen;
    int e_conv, e_fi, e_di, e_guard, e_proto, e_ifsc, e_cwi, e_bwi, e_crc;
    int e_spec, e_lock, e_sproto, e_hist, e_err;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_defaults();
        e_conv = 0; e_fi = 1; e_di = 1; e_guard = 0; e_proto = 0; e_ifsc = 32;
        e_cwi = 13; e_bwi = 4; e_crc = 0; e_spec = 0; e_lock = 0; e_sproto = 0;
        e_hist = 0; e_err = 0;
    endtask

    task automatic push(input logic [7:0] b);
        frame[flen] = b;
        flen++;
    endtask

    task automatic add_check_byte(input logic [7:0] flip);
        logic [7:0] x;
        x = 8'h00;
        for (int i = 1; i < flen; i++) x = x ^ frame[i];
        push(x ^ flip);
    endtask

    task automatic pulse_card_reset();
        @(negedge clk);
        card_reset = 1'b1;
        @(negedge clk);
        card_reset = 1'b0;
    endtask

    // Send the frame with an idle cycle of noise after each byte (R11).
    task automatic send_frame();
        int bad_done;
        bad_done = 0;
        for (int i = 0; i < flen; i++) begin
            byte_vld = 1'b1;
            byte_dat = frame[i];
            @(negedge clk);
            if (i < flen - 1 && done) bad_done++;
            if (i == flen - 1 && !done) bad_done++;
            byte_vld = 1'b0;
            byte_dat = 8'hA5;
            @(negedge clk);
            if (done) bad_done++;
        end
        chk("R8", "done timing errors", bad_done, 0);
    endtask

    task automatic check_fields();
        chk("R1", "conv_inverse", int'(conv_inverse), e_conv);
        chk("R3", "fi_idx", int'(fi_idx), e_fi);
        chk("R3", "di_idx", int'(di_idx), e_di);
        chk("R3", "guard_code", int'(guard_code), e_guard);
        chk("R4", "proto_type", int'(proto_type), e_proto);
        chk("R5", "spec_mode", int'(spec_mode), e_spec);
        chk("R5", "spec_lock", int'(spec_lock), e_lock);
        chk("R5", "spec_proto", int'(spec_proto), e_sproto);
        chk("R6", "ifsc", int'(ifsc), e_ifsc);
        chk("R6", "cwi", int'(cwi), e_cwi);
        chk("R6", "bwi", int'(bwi), e_bwi);
        chk("R6", "crc_sel", int'(crc_sel), e_crc);
        chk("R2", "hist_cnt", int'(hist_cnt), e_hist);
        chk("R9", "chk_err", int'(chk_err), e_err);
    endtask

    // Build one string from a first-group presence map and a shape code.
    task automatic build(input logic [3:0] y1, input logic [1:0] cfg);
        logic [3:0] h, y2, y3;
        logic [7:0] b;
        logic       p1;
        set_defaults();
        flen = 0;
        push(cfg[0] ? 8'h3F : 8'h3B);
        e_conv = cfg[0];
        h = y1 + 4'(cfg);
        push({y1, h});
        e_hist = h;
        if (y1[0]) begin
            b = 8'h95 ^ {y1, y1};
            push(b);
            e_fi = b[7:4];
            e_di = b[3:0];
        end
        if (y1[1]) push(8'h00);
        if (y1[2]) begin
            b = 8'h20 + {2'b00, y1, cfg};
            push(b);
            e_guard = b;
        end
        p1 = cfg[1];
        if (y1[3]) begin
            y2 = cfg[0] ? 4'b1001 : 4'b1000;
            push({y2, 3'b000, p1});
            e_proto = p1;
            if (cfg[0]) begin
                push(8'h81);
                e_spec = 1; e_lock = 1; e_sproto = 1;
            end
            y3 = cfg[1] ? 4'b0111 : 4'b0101;
            push({y3, 3'b000, p1});
            b = 8'h40 + {4'h0, y1};
            push(b);
            e_ifsc = b;
            if (y3[1]) begin
                push(8'h5A);
                e_bwi = 5;
                e_cwi = 10;
            end
            push({7'b0, cfg[0]});
            e_crc = cfg[0];
        end
        for (int k = 0; k < 16; k++) if (k < int'(h)) push(8'h30 + 8'(k));
        if (y1[3] && p1) begin
            add_check_byte(cfg == 2'd3 ? 8'h01 : 8'h00);
            e_err = (cfg == 2'd3) ? 1 : 0;
        end
    endtask

    initial begin
        logic [7:0] sample [0:14];
        sample = '{8'h44, 8'h4E, 8'h41, 8'h53, 8'h50, 8'h30, 8'h30, 8'h33,
                   8'h20, 8'h52, 8'h65, 8'h76, 8'h33, 8'h37, 8'h32};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        set_defaults();
        // R7: defaults straight out of reset
        check_fields();

        // Sweep of every first-group presence map against four chain shapes.
        for (int y = 0; y < 16; y++) begin
            for (int c = 0; c < 4; c++) begin
                pulse_card_reset();
                build(4'(y), 2'(c));
                send_frame();
                check_fields();
            end
        end

        // Full-length string with every group present: ifsc 100 expected (R6).
        pulse_card_reset();
        set_defaults();
        flen = 0;
        push(8'h3F); push(8'hFF); push(8'h95); push(8'h00); push(8'hFF);
        push(8'h91); push(8'h81); push(8'h71); push(8'h64); push(8'h47); push(8'h00);
        for (int k = 0; k < 15; k++) push(sample[k]);
        add_check_byte(8'h00);
        chk("R8", "string length", flen, 27);
        e_conv = 1; e_fi = 9; e_di = 5; e_guard = 8'hFF; e_proto = 1;
        e_spec = 1; e_lock = 1; e_sproto = 1; e_ifsc = 100; e_bwi = 4; e_cwi = 7;
        e_crc = 0; e_hist = 15; e_err = 0;
        send_frame();
        check_fields();

        // R10: bytes after completion are ignored.
        begin
            int extra_done;
            extra_done = 0;
            for (int k = 0; k < 4; k++) begin
                byte_vld = 1'b1;
                byte_dat = 8'h10 + 8'(k);
                @(negedge clk);
                if (done) extra_done++;
            end
            byte_vld = 1'b0;
            @(negedge clk);
            chk("R10", "done after completion", extra_done, 0);
            check_fields();
        end

        // R10/R7: card_reset restores defaults and a new string parses.
        pulse_card_reset();
        set_defaults();
        check_fields();
        flen = 0;
        push(8'h3B); push(8'h11); push(8'h18);
        set_defaults();
        e_fi = 1; e_di = 8; e_hist = 1;
        push(8'h77);
        send_frame();
        check_fields();

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule